// File: doc/BRIEF.md
# Multi-protocol transceiver mode decoder

This block is the control half of a serial line interface that can be switched between several electrical standards. A 4-bit mode word arrives through a level latch: the latch passes the word while its control input is high and holds the last word while that input is low. The block turns the latched word into per-channel controls for seven line drivers and seven line receivers. For each channel it produces a one-hot type select and an output enable. It also drives the switches for the V.11 and V.35 termination networks on the three clock/data receivers, and the two internal loopback path selects.

Each driver can be turned off on its own through a disable pin. The receiver on the serial clock channel (index 2) has its own enable pin. The all-off code overrides every one of these pins. Every decoded output is registered and follows the latch output one clock later.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `latch_n` is 1 the mode word passes through the latch, and the outputs reflect it after the next rising clock edge. While `latch_n` is 0 the outputs keep decoding the word held at the last edge where `latch_n` was 1.
- R2: Synchronous reset clears the held word to 0000 and drives every output to 0.
- R3: Code 0000, and every code not listed in R4 to R6, gives the all-off state. In that state all types, enables, terminations and loopback selects are 0, whatever the disable pins and `sct_en` are set to.
- R4: Code 0010 makes every driver and receiver V.28. Code 0100 makes every driver and receiver V.11. Driver type bits per channel are bit0 V.28, bit1 V.10, bit2 V.11, bit3 V.35, with channel i at bits [4i+3:4i]. Receiver type bits per channel are bit0 V.28, bit1 V.10, bit2 V.11, with channel i at bits [3i+2:3i].
- R5: Code 1110 makes drivers 0 to 2 V.35 and receivers 0 to 2 V.11, with the other channels V.28. Code 1101 makes drivers and receivers 0 to 2 V.11, with the other channels V.10.
- R6: Code 1010 sets `lb_se` and makes all types V.28. Code 1011 sets `lb_diff` and makes all types V.11. In both, every driver output enable is 0, all terminations are off, and the receivers stay enabled.
- R7: In modes 0010, 0100, 1101 and 1110, driver i is enabled exactly when `drv_dis[i]` is 0.
- R8: In every state except all-off, receiver outputs are enabled. The exception is receiver 2, which is enabled only while `sct_en` is 1.
- R9: The V.11 termination on receiver i (i from 0 to 2) is on only in modes 0100 and 1101 while that receiver is enabled. The V.35 termination is on only in mode 1110 while the receiver is enabled. The two are never on together.
- R10: Each channel's type field has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 4 | Interface mode code |
| latch_n | input | 1 | 1 = latch transparent, 0 = hold |
| drv_dis | input | 7 | Per-driver disable, 1 = tri-state |
| sct_en | input | 1 | Enable for receiver 2, active high |
| drv_type | output | 28 | One-hot driver type, 4 bits per channel |
| drv_oe | output | 7 | Driver line output enables |
| rx_type | output | 21 | One-hot receiver type, 3 bits per channel |
| rx_oe | output | 7 | Receiver output enables |
| term_v11 | output | 3 | V.11 termination switches, receivers 0 to 2 |
| term_v35 | output | 3 | V.35 termination switches, receivers 0 to 2 |
| lb_se | output | 1 | Single-ended loopback path select |
| lb_diff | output | 1 | Differential loopback path select |

## Verification
The hardest behaviour to reach is the held word diverging from the word on the pins. This happens when `latch_n` closes and `mode_word` then moves, and when a reset arrives while the latch is closed. The stimulus sets up that case directly: it opens the latch for a single cycle, closes it, and changes the pins to a different valid code. It then resets with the latch still closed, so the held word has to fall back to the all-off code even though the pins show a live mode.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  localparam int MODE_W = 4;
  localparam int DRV_TW = 4;
  localparam int RX_TW  = 3;

  localparam int DT_V28 = 0;
  localparam int DT_V10 = 1;
  localparam int DT_V11 = 2;
  localparam int DT_V35 = 3;
  localparam int RT_V28 = 0;
  localparam int RT_V10 = 1;
  localparam int RT_V11 = 2;

  localparam logic [MODE_W-1:0] CODE_SE      = 4'b0010;
  localparam logic [MODE_W-1:0] CODE_DIFF    = 4'b0100;
  localparam logic [MODE_W-1:0] CODE_MIX     = 4'b1101;
  localparam logic [MODE_W-1:0] CODE_V35     = 4'b1110;
  localparam logic [MODE_W-1:0] CODE_LB_SE   = 4'b1010;
  localparam logic [MODE_W-1:0] CODE_LB_DIFF = 4'b1011;

  typedef enum logic [2:0] {
    CL_OFF, CL_SE, CL_DIFF, CL_V35, CL_MIX, CL_LB_SE, CL_LB_DIFF
  } mode_cls_e;

  function automatic mode_cls_e classify(input logic [MODE_W-1:0] code);
    mode_cls_e c;
    case (code)
      CODE_SE:      c = CL_SE;
      CODE_DIFF:    c = CL_DIFF;
      CODE_MIX:     c = CL_MIX;
      CODE_V35:     c = CL_V35;
      CODE_LB_SE:   c = CL_LB_SE;
      CODE_LB_DIFF: c = CL_LB_DIFF;
      default:      c = CL_OFF;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/xcvr_mode_latch.sv
module xcvr_mode_latch
  import xcvr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              latch_n,
  output mode_cls_e         cls
);
  logic [MODE_W-1:0] hold_q;
  logic [MODE_W-1:0] eff;

  always_comb eff = latch_n ? mode_word : hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= eff;
  end

  assign cls = classify(eff);

  // R1: a closed latch keeps its word
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !latch_n |=> $stable(hold_q));
  // R1: an open latch captures the pins
  assert_track_R1: assert property (@(posedge clk) disable iff (rst)
    latch_n |=> hold_q == $past(mode_word));
endmodule

// File: rtl/xcvr_drv_decode.sv
module xcvr_drv_decode
  import xcvr_mode_pkg::*;
#(
  parameter int N_DRV  = 7,
  parameter int N_FAST = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  mode_cls_e               cls,
  input  logic [N_DRV-1:0]        drv_dis,
  output logic [N_DRV*DRV_TW-1:0] drv_type,
  output logic [N_DRV-1:0]        drv_oe,
  output logic                    lb_se,
  output logic                    lb_diff
);
  logic line_mode;
  always_comb line_mode = (cls == CL_SE) || (cls == CL_DIFF) ||
                          (cls == CL_V35) || (cls == CL_MIX);

  for (genvar i = 0; i < N_DRV; i++) begin : g_ch
    localparam bit FAST = (i < N_FAST);
    logic [DRV_TW-1:0] t;
    always_comb begin
      t = '0;
      case (cls)
        CL_SE, CL_LB_SE:     t[DT_V28] = 1'b1;
        CL_DIFF, CL_LB_DIFF: t[DT_V11] = 1'b1;
        CL_V35:              t[FAST ? DT_V35 : DT_V28] = 1'b1;
        CL_MIX:              t[FAST ? DT_V11 : DT_V10] = 1'b1;
        default:             t = '0;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        drv_type[i*DRV_TW +: DRV_TW] <= '0;
        drv_oe[i] <= 1'b0;
      end else begin
        drv_type[i*DRV_TW +: DRV_TW] <= t;
        drv_oe[i] <= line_mode && !drv_dis[i];
      end
    end
    // R7: a disabled driver is tri-stated
    assert_dis_R7: assert property (@(posedge clk) disable iff (rst)
      drv_dis[i] |=> !drv_oe[i]);
    // R10: one type per driver
    assert_onehot_drv_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(drv_type[i*DRV_TW +: DRV_TW]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_se   <= 1'b0;
      lb_diff <= 1'b0;
    end else begin
      lb_se   <= (cls == CL_LB_SE);
      lb_diff <= (cls == CL_LB_DIFF);
    end
  end
endmodule

// File: rtl/xcvr_rx_decode.sv
module xcvr_rx_decode
  import xcvr_mode_pkg::*;
#(
  parameter int N_RX    = 7,
  parameter int N_FAST  = 3,
  parameter int SCT_IDX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  mode_cls_e             cls,
  input  logic                  sct_en,
  output logic [N_RX*RX_TW-1:0] rx_type,
  output logic [N_RX-1:0]       rx_oe,
  output logic [N_FAST-1:0]     term_v11,
  output logic [N_FAST-1:0]     term_v35
);
  logic v11_mode;
  always_comb v11_mode = (cls == CL_DIFF) || (cls == CL_MIX);

  for (genvar i = 0; i < N_RX; i++) begin : g_ch
    localparam bit FAST = (i < N_FAST);
    localparam bit IS_SCT = (i == SCT_IDX);
    logic [RX_TW-1:0] t;
    logic en;
    always_comb begin
      t = '0;
      case (cls)
        CL_SE, CL_LB_SE:     t[RT_V28] = 1'b1;
        CL_DIFF, CL_LB_DIFF: t[RT_V11] = 1'b1;
        CL_V35:              t[FAST ? RT_V11 : RT_V28] = 1'b1;
        CL_MIX:              t[FAST ? RT_V11 : RT_V10] = 1'b1;
        default:             t = '0;
      endcase
      en = (cls != CL_OFF) && (!IS_SCT || sct_en);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        rx_type[i*RX_TW +: RX_TW] <= '0;
        rx_oe[i] <= 1'b0;
      end else begin
        rx_type[i*RX_TW +: RX_TW] <= t;
        rx_oe[i] <= en;
      end
    end
    // R10: one type per receiver
    assert_onehot_rx_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rx_type[i*RX_TW +: RX_TW]));

    if (FAST) begin : g_term
      always_ff @(posedge clk) begin
        if (rst) begin
          term_v11[i] <= 1'b0;
          term_v35[i] <= 1'b0;
        end else begin
          term_v11[i] <= v11_mode && en;
          term_v35[i] <= (cls == CL_V35) && en;
        end
      end
      // R9: termination only on an enabled receiver, never both networks
      assert_term_en_R9: assert property (@(posedge clk) disable iff (rst)
        (term_v11[i] || term_v35[i]) |-> rx_oe[i]);
      assert_term_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(term_v11[i] && term_v35[i]));
    end
  end

  // R8: clock receiver follows its enable pin
  assert_sct_R8: assert property (@(posedge clk) disable iff (rst)
    !sct_en |=> !rx_oe[SCT_IDX]);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int N_DRV   = 7,
  parameter int N_RX    = 7,
  parameter int N_FAST  = 3,
  parameter int SCT_IDX = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MODE_W-1:0]       mode_word,
  input  logic                    latch_n,
  input  logic [N_DRV-1:0]        drv_dis,
  input  logic                    sct_en,
  output logic [N_DRV*DRV_TW-1:0] drv_type,
  output logic [N_DRV-1:0]        drv_oe,
  output logic [N_RX*RX_TW-1:0]   rx_type,
  output logic [N_RX-1:0]         rx_oe,
  output logic [N_FAST-1:0]       term_v11,
  output logic [N_FAST-1:0]       term_v35,
  output logic                    lb_se,
  output logic                    lb_diff
);
  mode_cls_e cls;

  xcvr_mode_latch u_latch (
    .clk(clk), .rst(rst), .mode_word(mode_word), .latch_n(latch_n), .cls(cls)
  );

  xcvr_drv_decode #(.N_DRV(N_DRV), .N_FAST(N_FAST)) u_drv (
    .clk(clk), .rst(rst), .cls(cls), .drv_dis(drv_dis),
    .drv_type(drv_type), .drv_oe(drv_oe), .lb_se(lb_se), .lb_diff(lb_diff)
  );

  xcvr_rx_decode #(.N_RX(N_RX), .N_FAST(N_FAST), .SCT_IDX(SCT_IDX)) u_rx (
    .clk(clk), .rst(rst), .cls(cls), .sct_en(sct_en),
    .rx_type(rx_type), .rx_oe(rx_oe), .term_v11(term_v11), .term_v35(term_v35)
  );

  // R2: state right after reset is all zero
  assert_rst_R2: assert property (@(posedge clk)
    $past(rst) |-> (drv_oe == '0 && rx_oe == '0 && term_v11 == '0 &&
                    term_v35 == '0 && !lb_se && !lb_diff));
  // R3: all-off code clears everything whatever the pins say
  assert_off_R3: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_OFF) |=> (drv_oe == '0 && rx_oe == '0 && drv_type == '0 &&
                         rx_type == '0 && term_v11 == '0 && term_v35 == '0 &&
                         !lb_se && !lb_diff));
  // R6: loopback isolates the line side
  assert_lb_R6: assert property (@(posedge clk) disable iff (rst)
    (lb_se || lb_diff) |-> (drv_oe == '0 && term_v11 == '0 && term_v35 == '0));
  assert_lb_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lb_se, lb_diff}));
endmodule

// File: tb/tb_xcvr_mode_ctrl.sv
module tb_xcvr_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode_word = 4'b0000;
  logic        latch_n = 1'b1;
  logic [6:0]  drv_dis = '0;
  logic        sct_en = 1'b1;
  logic [27:0] drv_type;
  logic [6:0]  drv_oe;
  logic [20:0] rx_type;
  logic [6:0]  rx_oe;
  logic [2:0]  term_v11, term_v35;
  logic        lb_se, lb_diff;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xcvr_mode_ctrl dut (
    .clk(clk), .rst(rst), .mode_word(mode_word), .latch_n(latch_n),
    .drv_dis(drv_dis), .sct_en(sct_en), .drv_type(drv_type), .drv_oe(drv_oe),
    .rx_type(rx_type), .rx_oe(rx_oe), .term_v11(term_v11), .term_v35(term_v35),
    .lb_se(lb_se), .lb_diff(lb_diff)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Model of the type selects, written from R4, R5 and R6
  function automatic logic [27:0] m_drv_type(input logic [3:0] c);
    logic [27:0] r = '0;
    for (int i = 0; i < 7; i++) begin
      logic [3:0] t = 4'b0000;
      case (c)
        4'b0010, 4'b1010: t = 4'b0001;
        4'b0100, 4'b1011: t = 4'b0100;
        4'b1110:          t = (i < 3) ? 4'b1000 : 4'b0001;
        4'b1101:          t = (i < 3) ? 4'b0100 : 4'b0010;
        default:          t = 4'b0000;
      endcase
      r[i*4 +: 4] = t;
    end
    return r;
  endfunction

  function automatic logic [20:0] m_rx_type(input logic [3:0] c);
    logic [20:0] r = '0;
    for (int i = 0; i < 7; i++) begin
      logic [2:0] t = 3'b000;
      case (c)
        4'b0010, 4'b1010: t = 3'b001;
        4'b0100, 4'b1011: t = 3'b100;
        4'b1110:          t = (i < 3) ? 3'b100 : 3'b001;
        4'b1101:          t = (i < 3) ? 3'b100 : 3'b010;
        default:          t = 3'b000;
      endcase
      r[i*3 +: 3] = t;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0100: return "R4";
      4'b1110, 4'b1101: return "R5";
      4'b1010, 4'b1011: return "R6";
      default:          return "R3";
    endcase
  endfunction

  // {code, drv_dis, sct_en, exp drv_oe, exp rx_oe, exp v11, exp v35, exp {lb_diff,lb_se}}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {4'b0010, 7'h00, 1'b1, 7'h7F, 7'h7F, 3'b000, 3'b000, 2'b00},
    {4'b0100, 7'h00, 1'b1, 7'h7F, 7'h7F, 3'b111, 3'b000, 2'b00},
    {4'b0100, 7'h05, 1'b0, 7'h7A, 7'h7B, 3'b011, 3'b000, 2'b00},
    {4'b1110, 7'h00, 1'b1, 7'h7F, 7'h7F, 3'b000, 3'b111, 2'b00},
    {4'b1110, 7'h40, 1'b0, 7'h3F, 7'h7B, 3'b000, 3'b011, 2'b00},
    {4'b1101, 7'h00, 1'b1, 7'h7F, 7'h7F, 3'b111, 3'b000, 2'b00},
    {4'b1010, 7'h00, 1'b1, 7'h00, 7'h7F, 3'b000, 3'b000, 2'b01},
    {4'b1011, 7'h00, 1'b0, 7'h00, 7'h7B, 3'b000, 3'b000, 2'b10},
    {4'b0000, 7'h00, 1'b1, 7'h00, 7'h00, 3'b000, 3'b000, 2'b00},
    {4'b1111, 7'h00, 1'b1, 7'h00, 7'h00, 3'b000, 3'b000, 2'b00},
    {4'b0001, 7'h2A, 1'b0, 7'h00, 7'h00, 3'b000, 3'b000, 2'b00},
    {4'b0010, 7'h7F, 1'b0, 7'h00, 7'h7B, 3'b000, 3'b000, 2'b00}
  };

  task automatic check_all(input string tag, input logic [3:0] c,
                           input logic [6:0] e_doe, input logic [6:0] e_roe,
                           input logic [2:0] e_v11, input logic [2:0] e_v35,
                           input logic [1:0] e_lb);
    chk(tag, "drv_type R10", 32'(drv_type), 32'(m_drv_type(c)));
    chk(tag, "rx_type R10", 32'(rx_type), 32'(m_rx_type(c)));
    chk(tag, "drv_oe R7", 32'(drv_oe), 32'(e_doe));
    chk(tag, "rx_oe R8", 32'(rx_oe), 32'(e_roe));
    chk(tag, "term_v11 R9", 32'(term_v11), 32'(e_v11));
    chk(tag, "term_v35 R9", 32'(term_v35), 32'(e_v35));
    chk(tag, "loopback", 32'({lb_diff, lb_se}), 32'(e_lb));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check_all("R2", 4'b0000, 7'h00, 7'h00, 3'b000, 3'b000, 2'b00);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [33:0] v = VEC[k];
      @(negedge clk);
      mode_word = v[33:30];
      drv_dis   = v[29:23];
      sct_en    = v[22];
      latch_n   = 1'b1;
      @(negedge clk);
      check_all(tag_of(v[33:30]), v[33:30], v[21:15], v[14:8], v[7:5], v[4:2], v[1:0]);
    end

    // R1: latency of exactly one edge
    @(negedge clk);
    drv_dis = '0; sct_en = 1'b1; latch_n = 1'b1; mode_word = 4'b0100;
    @(negedge clk);
    mode_word = 4'b1110;
    #1 chk("R1", "before edge term_v11", 32'(term_v11), 32'h7);
    @(negedge clk);
    chk("R1", "after edge term_v35", 32'(term_v35), 32'h7);

    // R1: closed latch ignores the pins
    latch_n = 1'b0;
    mode_word = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "held V35 drv_type", 32'(drv_type), 32'(m_drv_type(4'b1110)));
    chk("R1", "held V35 term_v35", 32'(term_v35), 32'h7);

    // R1: one-cycle open window captures a new word
    latch_n = 1'b1; mode_word = 4'b1011;
    @(negedge clk);
    latch_n = 1'b0; mode_word = 4'b0100;
    @(negedge clk);
    chk("R1", "captured lb_diff", 32'(lb_diff), 32'h1);
    chk("R1", "captured drv_oe", 32'(drv_oe), 32'h0);

    // R2: reset with latch closed clears the held word
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R2", 4'b0000, 7'h00, 7'h00, 3'b000, 3'b000, 2'b00);

    // R8: sct_en toggling in V.11 mode
    latch_n = 1'b1; mode_word = 4'b0100; sct_en = 1'b0;
    @(negedge clk);
    chk("R8", "sct off rx_oe", 32'(rx_oe), 32'h7B);
    chk("R9", "sct off term_v11", 32'(term_v11), 32'h3);
    sct_en = 1'b1;
    @(negedge clk);
    chk("R8", "sct on rx_oe", 32'(rx_oe), 32'h7F);
    chk("R9", "sct on term_v11", 32'(term_v11), 32'h7);

    // R3: all-off overrides the pins
    mode_word = 4'b0000; drv_dis = '0; sct_en = 1'b1;
    @(negedge clk);
    chk("R3", "override rx_oe", 32'(rx_oe), 32'h0);
    chk("R3", "override drv_oe", 32'(drv_oe), 32'h0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule